// File: doc/BRIEF.md
# Bidirectional Binary/Gray Code Converter

This block translates a word between plain binary and reflected Gray code. A mode input picks the direction. When it is low, a binary word is encoded into Gray code. When it is high, a Gray word is decoded back into binary. The default width is 7 bits, and bit 6 is the most significant bit.

Both directions use one chain of XOR stages that ripples from the top bit down. The top output bit passes straight through. The bit below it is a plain XOR of the two top input bits. Every lower stage XORs its own input bit with a second operand picked by a small mux. That operand is the next-higher input bit when encoding and the next-higher result bit when decoding. So no second converter exists.

An optional output register, on by default, holds the result for one clock and raises a valid strobe beside it. With the register turned off, the result and strobe follow the inputs combinationally.

Top module: `gray_bin_xcoder`

## Requirements
- R1: With `dir_sel` = 0, output bit i equals input bit i XOR input bit i+1, and the top bit passes through, for every input word.
- R2: With `dir_sel` = 1, output bit i equals the XOR of all input bits from i up to the top bit, for every input word.
- R3: The top output bit equals the top input bit in both modes.
- R4: Output bit WIDTH-2 equals the XOR of input bits WIDTH-1 and WIDTH-2, whatever the mode.
- R5: Encoding any word and then decoding the encoded result returns the original word.
- R6: With the register enabled, the result of an input presented with `in_valid` high appears one clock later, and `out_valid` is high in exactly that cycle.
- R7: With the register enabled, a cycle with `in_valid` low leaves `out_word` unchanged, and `out_valid` is low in the following cycle.
- R8: During reset and after it, until the first valid input, `out_word` is all zeros and `out_valid` is 0.
- R9: With WIDTH = 2 and the register disabled, both modes give the correct result combinationally for all four words, and `out_valid` follows `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| dir_sel | input | 1 | 0: binary to Gray, 1: Gray to binary |
| in_word | input | WIDTH | Word to convert |
| out_valid | output | 1 | Result strobe |
| out_word | output | WIDTH | Converted word |

## Verification
A fault in one mux select or one chain stage corrupts only that bit and the bits below it, and only for the words and the mode that use the faulty path. For that reason every one of the 128 words is driven in both modes, and each result is compared one clock later against a model built from the bit formulas. A stale or wrongly loaded output register shows up in the first cycle after a gap in `in_valid`, or in the first cycle after reset. The round trip catches any decode error that still leaves a result that looks plausible.

// File: rtl/gray_bin_xcoder.sv
module gray_bin_xcoder #(
  parameter int WIDTH      = 7,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             dir_sel,
  input  logic [WIDTH-1:0] in_word,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_word
);

  logic [WIDTH-1:0] conv;

  // Ripple from the top bit: pass-through, plain XOR, then mux+XOR cells.
  always_comb begin
    conv[WIDTH-1] = in_word[WIDTH-1];
    conv[WIDTH-2] = in_word[WIDTH-1] ^ in_word[WIDTH-2];
    for (int i = WIDTH - 3; i >= 0; i--)
      conv[i] = in_word[i] ^ (dir_sel ? conv[i+1] : in_word[i+1]);
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_word  <= '0;
          out_valid <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_word <= conv;
        end
      end

      a_r1_encode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir_sel) |=> out_word == ($past(in_word) ^ ($past(in_word) >> 1)));

      a_r2_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_sel) |=> (out_word ^ (out_word >> 1)) == $past(in_word));

      a_r3_msb_pass: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[WIDTH-1] == $past(in_word[WIDTH-1]));

      a_r6_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

      a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_word) && !out_valid));
    end else begin : g_comb
      assign out_word  = conv;
      assign out_valid = in_valid;
    end
  endgenerate

endmodule

// File: tb/gray_bin_xcoder_tb_top.sv
module gray_bin_xcoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, dir_sel = 1'b0;
  logic [6:0] in_word = '0;
  logic out_valid;
  logic [6:0] out_word;
  logic v2 = 1'b0, m2 = 1'b0;
  logic [1:0] w2 = '0;
  logic ov2;
  logic [1:0] o2;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gray_bin_xcoder #(.WIDTH(7), .REGISTERED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir_sel(dir_sel),
    .in_word(in_word), .out_valid(out_valid), .out_word(out_word));

  gray_bin_xcoder #(.WIDTH(2), .REGISTERED(1'b0)) dut2_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .dir_sel(m2),
    .in_word(w2), .out_valid(ov2), .out_word(o2));

  function automatic int model(input int w, input int m, input int n);
    int r = 0, acc = 0;
    if (m == 0) return (w ^ (w >> 1)) & ((1 << n) - 1);
    for (int i = n - 1; i >= 0; i--) begin
      acc = acc ^ ((w >> i) & 1);
      r = r | (acc << i);
    end
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic m, input logic [6:0] w);
    @(negedge clk);
    in_valid = v; dir_sel = m; in_word = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    int last;
    int e;
    logic [6:0] g;
    repeat (3) @(negedge clk);
    check("R8 reset word", int'(out_word), 0);
    check("R8 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset word", int'(out_word), 0);
    check("R8 idle after reset valid", int'(out_valid), 0);

    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 128; w++) begin
        step(1'b1, m[0], w[6:0]);
        e = model(w, m, 7);
        check(m == 0 ? "R1 encode" : "R2 decode", int'(out_word), e);
        check("R6 valid strobe", int'(out_valid), 1);
        check("R3 msb", int'(out_word[6]), (w >> 6) & 1);
        check("R4 second bit", int'(out_word[5]), ((w >> 6) ^ (w >> 5)) & 1);
      end

    for (int w = 0; w < 128; w++) begin
      step(1'b1, 1'b0, w[6:0]);
      g = out_word;
      step(1'b1, 1'b1, g);
      check("R5 round trip", int'(out_word), w);
    end

    step(1'b1, 1'b0, 7'h55);
    last = int'(out_word);
    check("R6 load", last, model(7'h55, 0, 7));
    step(1'b0, 1'b1, 7'h2A);
    check("R7 hold word", int'(out_word), last);
    check("R7 valid low", int'(out_valid), 0);
    step(1'b0, 1'b0, 7'h7F);
    check("R7 hold word again", int'(out_word), last);

    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 4; w++) begin
        m2 = m[0]; w2 = w[1:0]; v2 = w[0];
        #1;
        check("R9 two-bit word", int'(o2), model(w, m, 2));
        check("R9 two-bit valid", int'(ov2), w & 1);
      end

    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R8 reset again word", int'(out_word), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #(200000 * 4);
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule